// File: doc/BRIEF.md
# Decimal Up-Counter with Conditionally Loaded Upper Bits

This block is a single-digit decimal counter in 8421 weighting. Every state bit is updated on the falling edge of the master clock. The least significant bit is triggered on every advancing edge and simply inverts. The three upper bits receive a trigger only on edges where the least significant bit is 1, which are the edges where it falls.

That trigger is the RTL model of a derived clock of the form g + p·clk with g = 0 and p = bit 0. It is written as a per-bit load enable rather than a gated clock net. Because the upper bits load only when bit 0 is 1, their next-state equations are reduced forms that are correct only in those cycles. In the other cycles the upper bits hold, and about half of all advancing cycles cause no upper-bit activity.

A parameter selects the reduced variant or a conventional variant. In the conventional variant all bits load on every advancing edge and use full modulo-ten next-state logic. Per-bit strobe outputs show in which cycles each bit is triggered, so the activity saving can be observed directly.

Top module: `bcdg_counter`

## Requirements
- R1: All state changes happen on the falling edge of `clk`; a rising edge never changes `count`.
- R2: With `rst` high at a falling edge, `count` becomes 0 on that edge, whatever the values of `cnt_en` and `count`.
- R3: With `rst` low and `cnt_en` high, `count` advances 0,1,2,...,9, and 9 is followed by 0.
- R4: On every advancing edge (`rst` low, `cnt_en` high), bit 0 of `count` inverts.
- R5: On an edge where bit 0 of `count` is 0, bits 3..1 of `count` keep their value.
- R6: In the reduced variant (`NEXT_STYLE` = NEXT_REDUCED), `upd_strobe[3:1]` are each 1 exactly when `rst` is low, `cnt_en` is high and bit 0 of `count` is 1. Otherwise they are 0.
- R7: With `rst` low and `cnt_en` low, no bit of `count` changes.
- R8: `upd_strobe[0]` is 1 exactly when `rst` is low and `cnt_en` is high.
- R9: After reset, `count` never holds a value above 9.
- R10: In the conventional variant (`NEXT_STYLE` = NEXT_FULL), `count` follows the same sequence as in the reduced variant. In that variant, `upd_strobe[3:1]` equal `upd_strobe[0]` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; state updates on its falling edge |
| rst | input | 1 | Synchronous active-high reset, clears the count |
| cnt_en | input | 1 | Count enable; when low, the count holds |
| count | output | 4 | Current decimal digit, bit 0 least significant |
| upd_strobe | output | 4 | Per-bit trigger indication for the coming falling edge, bit i for count bit i |

## Verification
A wrong reduced equation shows as a wrong digit on `count` right after the first falling edge that leaves an odd value, and that is never more than two advancing edges away. An upper bit loaded on the wrong edge corrupts `count` on the very next even-to-odd step. A wrong trigger mask shows at once on `upd_strobe`, within the same cycle, before the edge. Because the digit is compared with a plain modulo-ten reference after every edge across many wraps, enable gaps and mid-count resets, any divergence is seen within one clock period.

// File: rtl/bcdg_pkg.sv
package bcdg_pkg;
   localparam int unsigned DIGIT_BITS = 4;
   localparam int unsigned DIGIT_LAST = 9;

   typedef logic [DIGIT_BITS-1:0] digit_t;

   typedef enum logic {
      NEXT_REDUCED = 1'b0,
      NEXT_FULL    = 1'b1
   } next_style_e;
endpackage

// File: rtl/bcdg_trigger.sv
module bcdg_trigger #(
   parameter bcdg_pkg::next_style_e NEXT_STYLE = bcdg_pkg::NEXT_REDUCED,
   parameter int unsigned           DIGIT_W    = 4
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               cnt_en,
   input  logic               lsb,
   output logic [DIGIT_W-1:0] trig
);
   logic adv;
   assign adv = cnt_en & ~rst;

   for (genvar b = 0; b < DIGIT_W; b++) begin : g_bit
      if (b == 0) begin : g_lsb
         assign trig[b] = adv;
      end else if (NEXT_STYLE == bcdg_pkg::NEXT_REDUCED) begin : g_gated
         // derived trigger: propagate term is bit 0, generate term is 0
         assign trig[b] = adv & lsb;
      end else begin : g_free
         assign trig[b] = adv;
      end
   end

   if (NEXT_STYLE == bcdg_pkg::NEXT_REDUCED) begin : g_chk
      p_gated_only_odd_r6 : assert property (@(negedge clk) disable iff (rst)
         trig[DIGIT_W-1] |-> lsb);
   end
endmodule

// File: rtl/bcdg_lsb.sv
module bcdg_lsb (
   input  logic clk,
   input  logic rst,
   input  logic trig,
   output logic q
);
   always_ff @(negedge clk) begin
      if (rst)       q <= 1'b0;
      else if (trig) q <= ~q;
   end

   p_lsb_toggles_r4 : assert property (@(negedge clk) disable iff (rst)
      trig |=> (q != $past(q)));
endmodule

// File: rtl/bcdg_upper.sv
module bcdg_upper #(
   parameter bcdg_pkg::next_style_e NEXT_STYLE = bcdg_pkg::NEXT_REDUCED,
   parameter int unsigned           DIGIT_W    = 4
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               lsb,
   input  logic [DIGIT_W-2:0] trig,
   output logic [DIGIT_W-2:0] q
);
   localparam int unsigned UP_W = DIGIT_W - 1;

   logic [UP_W-1:0] nxt;

   if (NEXT_STYLE == bcdg_pkg::NEXT_REDUCED) begin : g_reduced
      // valid only when lsb is 1; q[0]=bit1, q[1]=bit2, q[2]=bit3
      assign nxt[0] = ~q[2] & ~q[0];
      assign nxt[1] = q[1] ^ q[0];
      assign nxt[2] = q[1] & q[0];
   end else begin : g_full
      logic [DIGIT_W-1:0] cur;
      logic [DIGIT_W-1:0] inc;
      assign cur = {q, lsb};
      assign inc = (cur == DIGIT_W'(bcdg_pkg::DIGIT_LAST)) ? '0 : cur + 1'b1;
      assign nxt = inc[DIGIT_W-1:1];
   end

   for (genvar k = 0; k < UP_W; k++) begin : g_ff
      always_ff @(negedge clk) begin
         if (rst)          q[k] <= 1'b0;
         else if (trig[k]) q[k] <= nxt[k];
      end
   end

   p_upper_hold_r5 : assert property (@(negedge clk) disable iff (rst)
      (!lsb) |=> (q == $past(q)));
endmodule

// File: rtl/bcdg_counter.sv
module bcdg_counter #(
   parameter bcdg_pkg::next_style_e NEXT_STYLE = bcdg_pkg::NEXT_REDUCED,
   parameter int unsigned           DIGIT_W    = bcdg_pkg::DIGIT_BITS
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               cnt_en,
   output logic [DIGIT_W-1:0] count,
   output logic [DIGIT_W-1:0] upd_strobe
);
   localparam int unsigned UP_W = DIGIT_W - 1;

   if (DIGIT_W != bcdg_pkg::DIGIT_BITS) begin : g_bad_width
      $error("bcdg_counter: DIGIT_W must be 4");
   end

   logic               lsb_q;
   logic [UP_W-1:0]    up_q;
   logic [DIGIT_W-1:0] trig;

   bcdg_trigger #(.NEXT_STYLE(NEXT_STYLE), .DIGIT_W(DIGIT_W)) u_trig (
      .clk(clk), .rst(rst), .cnt_en(cnt_en), .lsb(lsb_q), .trig(trig));

   bcdg_lsb u_lsb (.clk(clk), .rst(rst), .trig(trig[0]), .q(lsb_q));

   bcdg_upper #(.NEXT_STYLE(NEXT_STYLE), .DIGIT_W(DIGIT_W)) u_up (
      .clk(clk), .rst(rst), .lsb(lsb_q), .trig(trig[DIGIT_W-1:1]), .q(up_q));

   assign count      = {up_q, lsb_q};
   assign upd_strobe = trig;

   p_reset_clears_r2 : assert property (@(negedge clk)
      rst |=> (count == '0));
   p_wrap_r3 : assert property (@(negedge clk) disable iff (rst)
      (cnt_en && count == DIGIT_W'(bcdg_pkg::DIGIT_LAST)) |=> (count == '0));
   p_hold_r7 : assert property (@(negedge clk) disable iff (rst)
      (!cnt_en) |=> $stable(count));
   p_range_r9 : assert property (@(negedge clk) disable iff (rst)
      $past(rst) |-> (count <= DIGIT_W'(bcdg_pkg::DIGIT_LAST)));
endmodule

// File: tb/sim_bcdg_counter.sv
module sim_bcdg_counter;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       cnt_en = 1'b0;
   logic [3:0] cnt0, cnt1, stb0, stb1;
   int         checks = 0;
   int         fails = 0;
   int         refc = 0;

   always #4 clk = ~clk;

   bcdg_counter #(.NEXT_STYLE(bcdg_pkg::NEXT_REDUCED)) u0 (
      .clk(clk), .rst(rst), .cnt_en(cnt_en), .count(cnt0), .upd_strobe(stb0));
   bcdg_counter #(.NEXT_STYLE(bcdg_pkg::NEXT_FULL)) u1 (
      .clk(clk), .rst(rst), .cnt_en(cnt_en), .count(cnt1), .upd_strobe(stb1));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic cycle(input logic en, input logic r);
      logic adv;
      @(posedge clk);
      #1;
      rst = r;
      cnt_en = en;
      #1;
      adv = en & ~r;
      chk("R1 no change on rising edge", int'(cnt0), refc);
      chk("R8 strobe bit0", int'(stb0[0]), int'(adv));
      chk("R6 gated strobes", int'(stb0[3:1]), adv && refc[0] ? 7 : 0);
      chk("R10 full-variant strobes", int'(stb1), adv ? 15 : 0);
      @(negedge clk);
      if (r)       refc = 0;
      else if (en) refc = (refc == 9) ? 0 : refc + 1;
      #2;
      chk("R3 R4 R5 R7 count sequence", int'(cnt0), refc);
      chk("R10 full-variant count", int'(cnt1), refc);
      checks++;
      if (cnt0 > 4'd9) begin
         fails++;
         $display("FAIL R9: actual %0d expected <=9", cnt0);
      end
   endtask

   initial begin
      #(8 * 200000);
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      // R2: reset with enable high and low
      cycle(1'b1, 1'b1);
      cycle(1'b0, 1'b1);
      chk("R2 reset state", int'(cnt0), 0);
      // R3: plain run over several wraps
      for (int i = 0; i < 45; i++) cycle(1'b1, 1'b0);
      // R7: enable gaps at every digit
      for (int i = 0; i < 40; i++) cycle((i % 4) != 1, 1'b0);
      // R2: reset part-way through a count
      for (int i = 0; i < 7; i++) cycle(1'b1, 1'b0);
      cycle(1'b1, 1'b1);
      chk("R2 mid-count reset", int'(cnt0), 0);
      // mixed pattern with sporadic resets
      for (int i = 0; i < 300; i++)
         cycle((i % 7) != 3, (i % 53) == 29);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule